// File: doc/BRIEF.md
# Complementary-pair destructive-read access sequencer

This block is the timing controller for a memory array in which every stored bit is a pair of cells holding opposite values, and in which sensing a column wipes out what it held. For each byte request from an upstream controller, it steps through a fixed phase order: bit-line precharge, word-line enable, the plate pulse that dumps the selected column onto the bit lines, the sense decision and a restore write. It then answers the request. The length of each timed phase, in clock cycles, comes from a configuration input. A zero length is taken as one cycle.

The upper address bits pick one column, which is one word line, and the lower bits pick a byte within it. The whole column is sensed at once by comparing the true and complement bit line of every pair. The sensed column is held in a latch and driven back into the array during restore as true and complement data, so that the destructive read leaves the array unchanged. A write uses the same cycle. In restore, the new byte replaces the selected byte position and every other byte is restored with its old value. The response carries the byte that was sensed, which is the old contents for both reads and writes.

The default geometry is 256 columns of 256 bit pairs, giving 8192 bytes in total. The analog array and its sense physics stay outside the block. The bench contains a behavioural pair-cell model whose pairs are forced to an invalid equal state when read.

Top module: `pms_top`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `rsp_valid` is 0 and all array strobes (`arr_precharge`, `arr_wl_en`, `arr_plate`, `arr_sense`, `arr_restore`) are 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while idle. `req_valid` seen during an access has no effect on that access or on the array.
- R3: After a request is taken, the phases run in the order precharge, word line, plate, sense, restore and done. Each timed phase lasts the value on its `cyc_*` input, with 0 treated as 1. Done lasts exactly one cycle, and the block then returns to idle.
- R4: `arr_precharge`, `arr_plate`, `arr_sense` and `arr_restore` are each high only in their own phase, and at most one of them is high at a time. `arr_wl_en` is high from the word-line phase through the end of restore.
- R5: `arr_wl_sel` equals `req_addr[12:5]` of the accepted request and stays stable while `arr_wl_en` is high.
- R6: Bit i of the sensed column is 1 only when `arr_bl_t[i]`=1 and `arr_bl_c[i]`=0. Any other pair state, including a tie, senses as 0. The lines are sampled in the last sense cycle.
- R7: During restore, `arr_wr_t` is the sensed column and `arr_wr_c` is its bitwise complement. For a write, byte `req_addr[4:0]`, which occupies bits 8*k+7..8*k, is replaced by `req_wdata` and all other bytes keep their sensed value.
- R8: `rsp_valid` is a single-cycle pulse in the cycle directly after restore ends. `rsp_rdata` is then the sensed byte at the requested position, for both reads and writes.
- R9: When an access ends, no pair anywhere in the array is left in a corrupted state (true equal to complement).
- R10: Seen across successive accesses, a read returns the byte last written to that address, or the sensed value restored by the previous access to it. Accessing one byte never changes another byte in the same column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address {column, byte in column} |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle, can take a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 8 | Sensed (old) byte |
| cyc_precharge | input | 4 | Precharge phase length |
| cyc_wordline | input | 4 | Word-line settle phase length |
| cyc_plate | input | 4 | Plate pulse length |
| cyc_sense | input | 4 | Sense phase length |
| cyc_restore | input | 4 | Restore phase length |
| arr_precharge | output | 1 | Bit-line precharge strobe |
| arr_wl_en | output | 1 | Word-line enable |
| arr_wl_sel | output | 8 | Selected column |
| arr_plate | output | 1 | Plate-line pulse |
| arr_sense | output | 1 | Sense-amplifier enable |
| arr_restore | output | 1 | Restore write enable |
| arr_wr_t | output | 256 | Restore data, true cells |
| arr_wr_c | output | 256 | Restore data, complement cells |
| arr_bl_t | input | 256 | Sensed true bit lines |
| arr_bl_c | input | 256 | Sensed complement bit lines |

## Verification
A stuck or skipped phase shows up at the strobe ports within one cycle of the expected phase edge, because the bench predicts every strobe on every cycle from the configured lengths. A wrong column latch or byte merge shows up during restore as a wrong `arr_wr_t` value. It also leaves the model array with a wrong byte or a corrupted pair, which the end-of-access scan detects and which later reads return. A bad tie decision shows up in the response byte of the very access that sensed the tied pairs.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_PRECHARGE = 3'd1,
        PH_WORDLINE  = 3'd2,
        PH_PLATE     = 3'd3,
        PH_SENSE     = 3'd4,
        PH_RESTORE   = 3'd5,
        PH_DONE      = 3'd6
    } phase_e;

    typedef struct packed {
        logic precharge;
        logic wl_en;
        logic plate;
        logic sense;
        logic restore;
    } strobe_t;

    // Fixed phase order of one access
    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_IDLE:      return PH_PRECHARGE;
            PH_PRECHARGE: return PH_WORDLINE;
            PH_WORDLINE:  return PH_PLATE;
            PH_PLATE:     return PH_SENSE;
            PH_SENSE:     return PH_RESTORE;
            PH_RESTORE:   return PH_DONE;
            default:      return PH_IDLE;
        endcase
    endfunction

    // Phases whose length comes from a configuration input
    function automatic logic is_timed(phase_e p);
        return (p == PH_PRECHARGE) || (p == PH_WORDLINE) || (p == PH_PLATE) ||
               (p == PH_SENSE) || (p == PH_RESTORE);
    endfunction

    // Array strobes that belong to each phase
    function automatic strobe_t strobes_of(phase_e p);
        strobe_t s;
        s = '0;
        case (p)
            PH_PRECHARGE: s.precharge = 1'b1;
            PH_WORDLINE:  s.wl_en = 1'b1;
            PH_PLATE:     begin s.wl_en = 1'b1; s.plate = 1'b1; end
            PH_SENSE:     begin s.wl_en = 1'b1; s.sense = 1'b1; end
            PH_RESTORE:   begin s.wl_en = 1'b1; s.restore = 1'b1; end
            default:      s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pms_phase_timer.sv
module pms_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] remain_q;

    // Remaining cycles after the current one; zero length behaves as one
    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= (len == '0) ? '0 : len - CNT_W'(1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    assign last = (remain_q == '0);
endmodule

// File: rtl/pms_seq_fsm.sv
module pms_seq_fsm
    import pms_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   phase_last,
    output phase_e phase,
    output phase_e phase_nxt,
    output logic   advance
);
    phase_e phase_q;

    always_comb begin
        phase_nxt = phase_after(phase_q);
        case (phase_q)
            PH_IDLE: advance = start;
            PH_DONE: advance = 1'b1;
            default: advance = phase_last;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else if (advance) begin
            phase_q <= phase_nxt;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/pms_col_latch.sv
module pms_col_latch #(
    parameter int BSEL_W = 5,
    localparam int NBYTES = 1 << BSEL_W,
    localparam int NBITS = NBYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [NBITS-1:0]  bl_t,
    input  logic [NBITS-1:0]  bl_c,
    input  logic              is_write,
    input  logic [BSEL_W-1:0] byte_sel,
    input  logic [7:0]        wdata,
    output logic [NBITS-1:0]  col_q,
    output logic [7:0]        old_q
);
    logic [NBITS-1:0] decided;
    logic [NBITS-1:0] merged;

    // Pair decision: true line must win outright; ties read as zero
    assign decided = bl_t & ~bl_c;

    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        assign merged[b*8 +: 8] =
            (is_write && (byte_sel == BSEL_W'(b))) ? wdata : decided[b*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            old_q <= '0;
        end else if (capture) begin
            col_q <= merged;
            old_q <= decided[{byte_sel, 3'b000} +: 8];
        end
    end
endmodule

// File: rtl/pms_top.sv
module pms_top
    import pms_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 8,
    parameter int CNT_W  = 4,
    localparam int BSEL_W = ADDR_W - COL_W,
    localparam int COL_BITS = (1 << BSEL_W) * 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [7:0]          req_wdata,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [7:0]          rsp_rdata,
    input  logic [CNT_W-1:0]    cyc_precharge,
    input  logic [CNT_W-1:0]    cyc_wordline,
    input  logic [CNT_W-1:0]    cyc_plate,
    input  logic [CNT_W-1:0]    cyc_sense,
    input  logic [CNT_W-1:0]    cyc_restore,
    output logic                arr_precharge,
    output logic                arr_wl_en,
    output logic [COL_W-1:0]    arr_wl_sel,
    output logic                arr_plate,
    output logic                arr_sense,
    output logic                arr_restore,
    output logic [COL_BITS-1:0] arr_wr_t,
    output logic [COL_BITS-1:0] arr_wr_c,
    input  logic [COL_BITS-1:0] arr_bl_t,
    input  logic [COL_BITS-1:0] arr_bl_c
);
    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
    } req_t;

    req_t             req_q;
    phase_e           phase;
    phase_e           phase_nxt;
    logic             advance;
    logic             timer_last;
    logic             timer_load;
    logic [CNT_W-1:0] timer_len;
    logic             accept;
    strobe_t          strb;
    logic [COL_BITS-1:0] col_q;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q <= '{write: req_write, addr: req_addr, wdata: req_wdata};
        end
    end

    pms_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (req_valid),
        .phase_last (timer_last),
        .phase      (phase),
        .phase_nxt  (phase_nxt),
        .advance    (advance)
    );

    // Length of the phase being entered
    always_comb begin
        case (phase_nxt)
            PH_PRECHARGE: timer_len = cyc_precharge;
            PH_WORDLINE:  timer_len = cyc_wordline;
            PH_PLATE:     timer_len = cyc_plate;
            PH_SENSE:     timer_len = cyc_sense;
            PH_RESTORE:   timer_len = cyc_restore;
            default:      timer_len = '0;
        endcase
    end

    assign timer_load = advance && is_timed(phase_nxt);

    pms_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (timer_load),
        .len  (timer_len),
        .last (timer_last)
    );

    pms_col_latch #(.BSEL_W(BSEL_W)) u_col (
        .clk      (clk),
        .rst      (rst),
        .capture  ((phase == PH_SENSE) && timer_last),
        .bl_t     (arr_bl_t),
        .bl_c     (arr_bl_c),
        .is_write (req_q.write),
        .byte_sel (req_q.addr[BSEL_W-1:0]),
        .wdata    (req_q.wdata),
        .col_q    (col_q),
        .old_q    (rsp_rdata)
    );

    assign strb          = strobes_of(phase);
    assign arr_precharge = strb.precharge;
    assign arr_wl_en     = strb.wl_en;
    assign arr_plate     = strb.plate;
    assign arr_sense     = strb.sense;
    assign arr_restore   = strb.restore;
    assign arr_wl_sel    = req_q.addr[ADDR_W-1 -: COL_W];
    assign arr_wr_t      = col_q;
    assign arr_wr_c      = ~col_q;
    assign rsp_valid     = (phase == PH_DONE);
endmodule

// File: rtl/pms_top_chk.sv
module pms_top_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             arr_precharge,
    input logic             arr_wl_en,
    input logic [COL_W-1:0] arr_wl_sel,
    input logic             arr_plate,
    input logic             arr_sense,
    input logic             arr_restore
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({arr_precharge, arr_plate, arr_sense, arr_restore})); // R4

    AST_PLATE_UNDER_WL: assert property (@(posedge clk) disable iff (rst)
        arr_plate |-> arr_wl_en); // R4

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (arr_wl_en && $past(arr_wl_en)) |-> $stable(arr_wl_sel)); // R5

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R8

    AST_RSP_AFTER_RESTORE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(arr_restore)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(arr_wl_en || arr_precharge)); // R2

    AST_PRE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(arr_precharge) |-> $past(req_ready)); // R3
endmodule

bind pms_top pms_top_chk #(.COL_W(COL_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .arr_precharge (arr_precharge),
    .arr_wl_en     (arr_wl_en),
    .arr_wl_sel    (arr_wl_sel),
    .arr_plate     (arr_plate),
    .arr_sense     (arr_sense),
    .arr_restore   (arr_restore)
);

// File: tb/pms_top_tb_top.sv
module pms_top_tb_top;
    localparam int NCOL = 256;
    localparam int CB   = 256;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [7:0] rsp_rdata;
    logic [3:0] cyc_precharge = 4'd1, cyc_wordline = 4'd1, cyc_plate = 4'd1,
                cyc_sense = 4'd1, cyc_restore = 4'd1;
    logic arr_precharge, arr_wl_en, arr_plate, arr_sense, arr_restore;
    logic [7:0] arr_wl_sel;
    logic [CB-1:0] arr_wr_t, arr_wr_c, arr_bl_t, arr_bl_c;
    logic [CB-1:0] tie_mask = '0;

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 0;

    pms_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cyc_precharge(cyc_precharge), .cyc_wordline(cyc_wordline),
        .cyc_plate(cyc_plate), .cyc_sense(cyc_sense), .cyc_restore(cyc_restore),
        .arr_precharge(arr_precharge), .arr_wl_en(arr_wl_en), .arr_wl_sel(arr_wl_sel),
        .arr_plate(arr_plate), .arr_sense(arr_sense), .arr_restore(arr_restore),
        .arr_wr_t(arr_wr_t), .arr_wr_c(arr_wr_c), .arr_bl_t(arr_bl_t), .arr_bl_c(arr_bl_c)
    );

    function automatic logic [7:0] init_byte(int c, int b);
        return 8'(c * 7 + b * 29 + 60);
    endfunction

    // Behavioural pair-cell array: plate rise dumps the column and corrupts it
    logic [CB-1:0] cell_t [NCOL];
    logic [CB-1:0] cell_c [NCOL];
    logic [CB-1:0] bl_t_q, bl_c_q;
    logic plate_d;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCOL; c++) begin
                for (int b = 0; b < 32; b++) begin
                    cell_t[c][b*8 +: 8] <= init_byte(c, b);
                    cell_c[c][b*8 +: 8] <= ~init_byte(c, b);
                end
            end
            bl_t_q <= '0; bl_c_q <= '0; plate_d <= 1'b0;
        end else begin
            if (arr_precharge) begin bl_t_q <= '0; bl_c_q <= '0; end
            if (arr_plate && arr_wl_en && !plate_d) begin
                bl_t_q <= cell_t[arr_wl_sel];
                bl_c_q <= cell_c[arr_wl_sel];
                cell_t[arr_wl_sel] <= '1;
                cell_c[arr_wl_sel] <= '1;
            end
            if (arr_restore && arr_wl_en) begin
                cell_t[arr_wl_sel] <= arr_wr_t;
                cell_c[arr_wl_sel] <= arr_wr_c;
            end
            plate_d <= arr_plate;
        end
    end

    assign arr_bl_t = bl_t_q;
    assign arr_bl_c = bl_c_q | (tie_mask & bl_t_q);

    // Expected byte contents
    logic [7:0] shadow [int];

    function automatic logic [7:0] shadow_byte(int a);
        if (shadow.exists(a)) return shadow[a];
        return init_byte(a / 32, a % 32);
    endfunction

    function automatic logic [CB-1:0] col_now(int c);
        logic [CB-1:0] v;
        for (int b = 0; b < 32; b++) v[b*8 +: 8] = shadow_byte(c * 32 + b);
        return v;
    endfunction

    // Reference timeline
    bit busy = 0;
    int o = 0, P = 1, W = 1, L = 1, S = 1, R = 1;
    logic [12:0] a_q = '0;
    logic w_q = 1'b0;
    logic [7:0] d_q = '0;
    logic [CB-1:0] tie_q = '0;

    function automatic int eff(logic [3:0] x);
        return (x == 4'd0) ? 1 : int'(x);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            busy = 0; o = 0;
        end else if (busy) begin
            if (o == P + W + L + S + R) busy = 0;
            else o++;
        end else if (req_valid) begin
            busy = 1; o = 0;
            P = eff(cyc_precharge); W = eff(cyc_wordline); L = eff(cyc_plate);
            S = eff(cyc_sense); R = eff(cyc_restore);
            a_q = req_addr; w_q = req_write; d_q = req_wdata; tie_q = tie_mask;
        end
    end

    task automatic chk(string tag, logic [CB-1:0] act, logic [CB-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            int T, ps, ss, rs;
            logic [CB-1:0] ecol;
            logic [7:0] eold;
            T  = P + W + L + S + R;
            ps = P + W; ss = ps + L; rs = ss + S;
            chk("R2 ready", CB'(req_ready), CB'(!busy));
            chk("R3 precharge", CB'(arr_precharge), CB'(busy && o < P));
            chk("R4 wordline", CB'(arr_wl_en), CB'(busy && o >= P && o < T));
            chk("R4 plate", CB'(arr_plate), CB'(busy && o >= ps && o < ss));
            chk("R4 sense", CB'(arr_sense), CB'(busy && o >= ss && o < rs));
            chk("R4 restore", CB'(arr_restore), CB'(busy && o >= rs && o < T));
            chk("R8 rsp_valid", CB'(rsp_valid), CB'(busy && o == T));
            if (busy && o >= P && o < T)
                chk("R5 wl_sel", CB'(arr_wl_sel), CB'(a_q[12:5]));
            ecol = col_now(int'(a_q[12:5])) & ~tie_q;
            eold = ecol[{a_q[4:0], 3'b000} +: 8];
            if (w_q) ecol[{a_q[4:0], 3'b000} +: 8] = d_q;
            if (busy && o >= rs && o < T) begin
                chk("R7 wr_t", arr_wr_t, ecol);
                chk("R7 wr_c", arr_wr_c, ~ecol);
            end
            if (busy && o == T) begin
                int nbad;
                chk("R6/R10 rdata", CB'(rsp_rdata), CB'(eold));
                nbad = 0;
                for (int c = 0; c < NCOL; c++)
                    if (cell_t[c] !== ~cell_c[c]) nbad++;
                chk("R9 corrupted pairs", CB'(nbad), CB'(0));
                for (int b = 0; b < 32; b++)
                    shadow[int'(a_q[12:5]) * 32 + b] = ecol[b*8 +: 8];
            end
        end
    end

    task automatic access(bit w, logic [12:0] a, logic [7:0] d,
                          int p, int wl, int pl, int s, int r, bit noisy);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cyc_precharge = 4'(p); cyc_wordline = 4'(wl); cyc_plate = 4'(pl);
        cyc_sense = 4'(s); cyc_restore = 4'(r);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (noisy) begin
            // R2: requests during an access must be ignored
            req_valid = 1'b1; req_write = ~w; req_addr = ~a; req_wdata = ~d;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!rsp_valid) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 ready", CB'(req_ready), CB'(1));
        chk("R1 rsp_valid", CB'(rsp_valid), CB'(0));
        chk("R1 strobes", CB'({arr_precharge, arr_wl_en, arr_plate, arr_sense, arr_restore}), CB'(0));

        access(0, 13'd0,    8'h00, 1, 1, 1, 1, 1, 0);     // R3 shortest
        access(0, 13'd8191, 8'h00, 3, 2, 4, 2, 5, 0);     // R5 top address
        access(0, 13'd40,   8'h00, 0, 0, 0, 0, 0, 0);     // R3 zero lengths
        access(0, 13'd77,   8'h00, 15, 15, 15, 15, 15, 0); // R3 maximum lengths
        access(1, 13'd100,  8'hA5, 2, 1, 2, 1, 2, 0);     // R7 write
        access(0, 13'd100,  8'h00, 1, 2, 1, 2, 1, 0);     // R10 read back
        access(0, 13'd101,  8'h00, 1, 1, 1, 1, 1, 0);     // R10 neighbour kept
        access(0, 13'd100,  8'h00, 1, 1, 1, 1, 1, 0);     // R9 repeated read
        access(1, 13'd3000, 8'h3C, 2, 2, 2, 2, 2, 1);     // R2 noise during write
        access(0, 13'd3000, 8'h00, 1, 1, 1, 1, 1, 0);
        // R6: tie on high nibble of byte 4 in column 3 senses as zero
        tie_mask = '0;
        tie_mask[4*8 +: 8] = 8'hF0;
        access(0, 13'd100,  8'h00, 1, 1, 1, 1, 1, 0);
        tie_mask = '0;
        access(0, 13'd100,  8'h00, 1, 1, 1, 1, 1, 0);
        for (int i = 0; i < 24; i++) begin
            access(i[0], 13'((i * 1237 + 11) % 8192), 8'(i * 53 + 7),
                   i % 5, (i + 1) % 4, (i + 2) % 6, i % 3, (i + 3) % 5, i[1]);
        end
        for (int i = 0; i < 24; i++) begin
            access(0, 13'((i * 1237 + 11) % 8192), 8'h00, 1, 1, 2, 1, 1, 0);
        end
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule